// File: doc/BRIEF.md
# Countdown Kitchen Timer Controller

This block keeps a minutes-and-seconds time value as four BCD digits and either counts it down to zero (timer mode) or counts it up from zero (stopwatch mode). The start value comes from one of three cooking presets or is adjusted a minute at a time with push buttons. When a countdown ends, the counter halts and a done LED lights.

All logic runs on the system clock. The one-second pace comes from a clock-enable input, `tick_en`, which is high for one cycle per second. An external divider produces it, for example by dividing a 5 MHz clock by 5,000,000. The button inputs are single-cycle pulses that are already debounced. The four digit outputs go to a separate seven-segment scan driver.

Priority within one cycle is: mode change, then start/stop, then preset, then increment/decrement. A tick is used only by a running counter, and only in a cycle that carries no mode change and no start/stop pulse.

Top module: `kitchen_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the time becomes 00:00, `running` and `done_led` go low, and the preset selector returns to its first entry.
- R2: In timer mode, while stopped, a `btn_preset` pulse loads the next preset and clears `done_led`. The presets come in the order 06:00, 08:00, 11:00 and then wrap back to 06:00. The first load after reset gives 06:00.
- R3: In timer mode, while stopped, `btn_inc` alone adds one minute and keeps the seconds. At minute 99 it instead sets 99:59. `btn_dec` alone subtracts one minute. At minute 00 it instead sets 00:00. Either press alone clears `done_led`. Both pressed in the same cycle have no effect.
- R4: In timer mode, `btn_start` stops a running countdown. It starts a stopped countdown whose time is not 00:00. At 00:00 it is ignored. In a cycle with `btn_start`, the other buttons and the tick are ignored.
- R5: A running countdown subtracts one second on each `tick_en` cycle. After a borrow, the seconds go from 00 to 59 and the minutes drop by one. A stopped counter ignores `tick_en`.
- R6: When a countdown reaches 00:00, `running` drops and `done_led` rises in the same cycle. `done_led` stays high until a preset, increment, decrement, mode change or reset. `done_led` and `running` are never high together.
- R7: While a countdown runs, `btn_inc`, `btn_dec` and `btn_preset` have no effect.
- R8: With `mode_sw` high (stopwatch), `btn_start` toggles counting. Each tick while counting adds one second, and the count saturates at 99:59 while `running` stays high. `btn_inc`, `btn_dec` and `btn_preset` are ignored, and `done_led` stays low.
- R9: A change of `mode_sw` clears the time to 00:00 and drops `running` and `done_led`. All buttons and the tick are ignored in that cycle.
- R10: All outputs are registered and change at the clock edge that samples the stimulus. The digits are always valid BCD, and the seconds tens digit never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per second |
| btn_inc | input | 1 | Add one minute (pulse) |
| btn_dec | input | 1 | Subtract one minute (pulse) |
| btn_start | input | 1 | Start/stop toggle (pulse) |
| btn_preset | input | 1 | Load next cooking preset (pulse) |
| mode_sw | input | 1 | 0 = countdown timer, 1 = stopwatch |
| min_tens | output | 4 | Minutes tens BCD digit |
| min_ones | output | 4 | Minutes ones BCD digit |
| sec_tens | output | 4 | Seconds tens BCD digit |
| sec_ones | output | 4 | Seconds ones BCD digit |
| running | output | 1 | Counter is advancing |
| done_led | output | 1 | Countdown has reached zero |

## Verification
Every result is due exactly one clock edge after the stimulus. This applies to a button, a tick, a mode change or reset, and to the time digits, `running` and `done_led` alike. The bench drives each stimulus on the falling edge and updates its model at the next rising edge. It compares all outputs shortly after that edge, so every comparison sees the state that edge produced and no later one. Countdowns to zero, saturation at both ends and preset wrap-around are all checked on that same one-edge schedule.

// File: rtl/kt_pkg.sv
package kt_pkg;
  localparam int DIGIT_W     = 4;
  localparam int NUM_PRESETS = 3;
  localparam int PRESET_IDX_W = (NUM_PRESETS > 1) ? $clog2(NUM_PRESETS) : 1;

  typedef struct packed {
    logic [DIGIT_W-1:0] m1;
    logic [DIGIT_W-1:0] m0;
    logic [DIGIT_W-1:0] s1;
    logic [DIGIT_W-1:0] s0;
  } kt_time_t;

  localparam kt_time_t KT_ZERO = '0;
  localparam kt_time_t KT_MAX  = '{m1: 4'd9, m0: 4'd9, s1: 4'd5, s0: 4'd9};

  function automatic int unsigned kt_preset_minutes(input int unsigned idx);
    case (idx)
      0:       return 6;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic kt_time_t kt_from_minutes(input int unsigned mins);
    kt_time_t t;
    t.m1 = DIGIT_W'(mins / 10);
    t.m0 = DIGIT_W'(mins % 10);
    t.s1 = '0;
    t.s0 = '0;
    return t;
  endfunction
endpackage

// File: rtl/kt_preset_sel.sv
module kt_preset_sel
  import kt_pkg::*;
#(
  parameter int NUM = NUM_PRESETS
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     advance,
  output kt_time_t preset_val
);
  localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1;

  logic [IDX_W-1:0] idx_q;
  kt_time_t         table_w [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_tbl
    assign table_w[g] = kt_from_minutes(kt_preset_minutes(g));
  end

  always_comb begin
    preset_val = KT_ZERO;
    for (int i = 0; i < NUM; i++) begin
      if (idx_q == IDX_W'(i)) preset_val = table_w[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= (idx_q == IDX_W'(NUM - 1)) ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/kt_bcd_step.sv
module kt_bcd_step
  import kt_pkg::*;
(
  input  kt_time_t cur,
  output kt_time_t sec_up,
  output kt_time_t sec_down,
  output kt_time_t min_up,
  output kt_time_t min_down,
  output logic     is_zero,
  output logic     is_one
);
  logic min_is_max, min_is_zero;

  assign is_zero     = (cur == KT_ZERO);
  assign is_one      = (cur.m1 == 0) && (cur.m0 == 0) && (cur.s1 == 0) && (cur.s0 == 4'd1);
  assign min_is_max  = (cur.m1 == 4'd9) && (cur.m0 == 4'd9);
  assign min_is_zero = (cur.m1 == 0) && (cur.m0 == 0);

  // one second forward, saturating at the top
  always_comb begin
    sec_up = cur;
    if (cur != KT_MAX) begin
      if (cur.s0 != 4'd9) begin
        sec_up.s0 = cur.s0 + 4'd1;
      end else begin
        sec_up.s0 = '0;
        if (cur.s1 != 4'd5) begin
          sec_up.s1 = cur.s1 + 4'd1;
        end else begin
          sec_up.s1 = '0;
          if (cur.m0 != 4'd9) begin
            sec_up.m0 = cur.m0 + 4'd1;
          end else begin
            sec_up.m0 = '0;
            sec_up.m1 = cur.m1 + 4'd1;
          end
        end
      end
    end
  end

  // one second back, holding at zero
  always_comb begin
    sec_down = cur;
    if (!is_zero) begin
      if (cur.s0 != 0) begin
        sec_down.s0 = cur.s0 - 4'd1;
      end else begin
        sec_down.s0 = 4'd9;
        if (cur.s1 != 0) begin
          sec_down.s1 = cur.s1 - 4'd1;
        end else begin
          sec_down.s1 = 4'd5;
          if (cur.m0 != 0) begin
            sec_down.m0 = cur.m0 - 4'd1;
          end else begin
            sec_down.m0 = 4'd9;
            sec_down.m1 = cur.m1 - 4'd1;
          end
        end
      end
    end
  end

  // whole-minute steps
  always_comb begin
    min_up = cur;
    if (min_is_max) begin
      min_up = KT_MAX;
    end else if (cur.m0 != 4'd9) begin
      min_up.m0 = cur.m0 + 4'd1;
    end else begin
      min_up.m0 = '0;
      min_up.m1 = cur.m1 + 4'd1;
    end
  end

  always_comb begin
    min_down = cur;
    if (min_is_zero) begin
      min_down = KT_ZERO;
    end else if (cur.m0 != 0) begin
      min_down.m0 = cur.m0 - 4'd1;
    end else begin
      min_down.m0 = 4'd9;
      min_down.m1 = cur.m1 - 4'd1;
    end
  end
endmodule

// File: rtl/kt_ctrl.sv
module kt_ctrl
  import kt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick_en,
  input  logic     btn_inc,
  input  logic     btn_dec,
  input  logic     btn_start,
  input  logic     btn_preset,
  input  logic     mode_sw,
  input  kt_time_t sec_up,
  input  kt_time_t sec_down,
  input  kt_time_t min_up,
  input  kt_time_t min_down,
  input  logic     is_zero,
  input  logic     is_one,
  input  kt_time_t preset_val,
  output kt_time_t time_q,
  output logic     run_q,
  output logic     done_q,
  output logic     mode_q,
  output logic     preset_adv
);
  kt_time_t time_n;
  logic     run_n, done_n;
  logic     mode_flip;

  assign mode_flip = (mode_sw != mode_q);

  always_comb begin
    time_n     = time_q;
    run_n      = run_q;
    done_n     = done_q;
    preset_adv = 1'b0;
    if (mode_flip) begin
      time_n = KT_ZERO;
      run_n  = 1'b0;
      done_n = 1'b0;
    end else if (mode_q) begin
      if (btn_start) begin
        run_n = !run_q;
      end else if (run_q && tick_en) begin
        time_n = sec_up;
      end
    end else if (btn_start) begin
      if (run_q) begin
        run_n = 1'b0;
      end else if (!is_zero) begin
        run_n = 1'b1;
      end
    end else if (run_q) begin
      if (tick_en) begin
        time_n = sec_down;
        if (is_one) begin
          run_n  = 1'b0;
          done_n = 1'b1;
        end
      end
    end else if (btn_preset) begin
      time_n     = preset_val;
      preset_adv = 1'b1;
      done_n     = 1'b0;
    end else if (btn_inc != btn_dec) begin
      time_n = btn_inc ? min_up : min_down;
      done_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= KT_ZERO;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      mode_q <= mode_sw;
    end else begin
      time_q <= time_n;
      run_q  <= run_n;
      done_q <= done_n;
      mode_q <= mode_sw;
    end
  end
endmodule

// File: rtl/kitchen_timer.sv
module kitchen_timer
  import kt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               btn_inc,
  input  logic               btn_dec,
  input  logic               btn_start,
  input  logic               btn_preset,
  input  logic               mode_sw,
  output logic [DIGIT_W-1:0] min_tens,
  output logic [DIGIT_W-1:0] min_ones,
  output logic [DIGIT_W-1:0] sec_tens,
  output logic [DIGIT_W-1:0] sec_ones,
  output logic               running,
  output logic               done_led
);
  kt_time_t time_w, sec_up_w, sec_down_w, min_up_w, min_down_w, preset_w;
  logic     is_zero_w, is_one_w, preset_adv_w, mode_reg;

  kt_preset_sel #(.NUM(NUM_PRESETS)) preset_i (
    .clk(clk), .rst(rst), .advance(preset_adv_w), .preset_val(preset_w)
  );

  kt_bcd_step step_i (
    .cur(time_w), .sec_up(sec_up_w), .sec_down(sec_down_w),
    .min_up(min_up_w), .min_down(min_down_w),
    .is_zero(is_zero_w), .is_one(is_one_w)
  );

  kt_ctrl ctrl_i (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .btn_inc(btn_inc), .btn_dec(btn_dec), .btn_start(btn_start),
    .btn_preset(btn_preset), .mode_sw(mode_sw),
    .sec_up(sec_up_w), .sec_down(sec_down_w),
    .min_up(min_up_w), .min_down(min_down_w),
    .is_zero(is_zero_w), .is_one(is_one_w), .preset_val(preset_w),
    .time_q(time_w), .run_q(running), .done_q(done_led),
    .mode_q(mode_reg), .preset_adv(preset_adv_w)
  );

  assign min_tens = time_w.m1;
  assign min_ones = time_w.m0;
  assign sec_tens = time_w.s1;
  assign sec_ones = time_w.s0;
endmodule

// File: rtl/kt_checker.sv
module kt_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick_en,
  input logic       btn_inc,
  input logic       btn_dec,
  input logic       btn_start,
  input logic       btn_preset,
  input logic       mode_sw,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_ones,
  input logic       running,
  input logic       done_led,
  input logic       mode_reg
);
  logic [15:0] digits;
  logic        no_btn;
  assign digits = {min_tens, min_ones, sec_tens, sec_ones};
  assign no_btn = !btn_inc && !btn_dec && !btn_start && !btn_preset;

  // R10
  bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (min_tens <= 4'd9) && (min_ones <= 4'd9) && (sec_tens <= 4'd5) && (sec_ones <= 4'd9));

  // R6
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done_led |-> !running);

  // R4
  run_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(btn_start));

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_led) |-> ($past(running) && $past(tick_en)));

  // R8
  sw_done_low_chk: assert property (@(posedge clk) disable iff (rst)
    mode_reg |-> !done_led);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!running && no_btn && (mode_sw == mode_reg)) |=> $stable(digits));

  // R7
  run_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !tick_en && (mode_sw == mode_reg)) |=> $stable(digits));
endmodule

bind kitchen_timer kt_checker chk_i (
  .clk(clk), .rst(rst), .tick_en(tick_en),
  .btn_inc(btn_inc), .btn_dec(btn_dec), .btn_start(btn_start),
  .btn_preset(btn_preset), .mode_sw(mode_sw),
  .min_tens(min_tens), .min_ones(min_ones),
  .sec_tens(sec_tens), .sec_ones(sec_ones),
  .running(running), .done_led(done_led), .mode_reg(mode_reg)
);

// File: tb/kitchen_timer_tb_top.sv
module kitchen_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst, tick_en, btn_inc, btn_dec, btn_start, btn_preset, mode_sw;
  logic [3:0] min_tens, min_ones, sec_tens, sec_ones;
  logic running, done_led;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_t, exp_idx;
  bit exp_run, exp_done, exp_mode;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kitchen_timer dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .btn_inc(btn_inc), .btn_dec(btn_dec), .btn_start(btn_start),
    .btn_preset(btn_preset), .mode_sw(mode_sw),
    .min_tens(min_tens), .min_ones(min_ones),
    .sec_tens(sec_tens), .sec_ones(sec_ones),
    .running(running), .done_led(done_led)
  );

  function automatic int preset_secs(input int i);
    return (i == 0) ? 360 : (i == 1) ? 480 : 660;
  endfunction

  function automatic logic [15:0] to_digits(input int t);
    int m, s;
    m = t / 60;
    s = t % 60;
    return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  task automatic compare(input string tag);
    logic [17:0] got, exp;
    got = {min_tens, min_ones, sec_tens, sec_ones, running, done_led};
    exp = {to_digits(exp_t), exp_run, exp_done};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h:%h:%h:%h run=%b done=%b, expected %h run=%b done=%b",
               tag, got[17:14], got[13:10], got[9:6], got[5:2], got[1], got[0],
               exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic model(input bit tk, st, inc, dec, pre, md, output string tag);
    tag = "R10";
    if (md != exp_mode) begin
      exp_mode = md; exp_t = 0; exp_run = 0; exp_done = 0; tag = "R9";
    end else if (exp_mode) begin
      tag = "R8";
      if (st) exp_run = !exp_run;
      else if (exp_run && tk && exp_t < 5999) exp_t++;
    end else if (st) begin
      tag = "R4";
      if (exp_run) exp_run = 0;
      else if (exp_t != 0) exp_run = 1;
    end else if (exp_run) begin
      if (tk) begin
        exp_t--; tag = "R5";
        if (exp_t == 0) begin exp_run = 0; exp_done = 1; tag = "R6"; end
      end else if (inc || dec || pre) tag = "R7";
    end else if (pre) begin
      exp_t = preset_secs(exp_idx);
      exp_idx = (exp_idx == 2) ? 0 : exp_idx + 1;
      exp_done = 0; tag = "R2";
    end else if (inc != dec) begin
      if (inc) exp_t = (exp_t / 60 >= 99) ? 5999 : exp_t + 60;
      else     exp_t = (exp_t < 60) ? 0 : exp_t - 60;
      exp_done = 0; tag = "R3";
    end else if (tk) tag = "R5";
  endtask

  task automatic cyc(input bit tk, st, inc, dec, pre, md);
    string tag;
    @(negedge clk);
    tick_en = tk; btn_start = st; btn_inc = inc; btn_dec = dec;
    btn_preset = pre; mode_sw = md;
    @(posedge clk);
    model(tk, st, inc, dec, pre, md, tag);
    #1;
    compare(tag);
  endtask

  task automatic do_reset(input bit md);
    @(negedge clk);
    rst = 1; mode_sw = md; tick_en = 0; btn_start = 0; btn_inc = 0;
    btn_dec = 0; btn_preset = 0;
    repeat (2) @(posedge clk);
    exp_t = 0; exp_run = 0; exp_done = 0; exp_idx = 0; exp_mode = md;
    #1;
    compare("R1");
    @(negedge clk);
    rst = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    rst = 1; tick_en = 0; btn_inc = 0; btn_dec = 0; btn_start = 0;
    btn_preset = 0; mode_sw = 0;
    do_reset(0);
    // R3: decrement at zero holds 00:00; R4: start at zero ignored
    cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    // R2: preset order and wrap
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0);
    // R3: saturate upward, both buttons ignored
    for (int i = 0; i < 100; i++) cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 0, 0);
    for (int i = 0; i < 99; i++) cyc(0, 0, 0, 1, 0, 0);
    // R2 then R3 down to 01:00, run to zero (R5, R6)
    cyc(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 1, 0);          // R7 ignored buttons (tick also counts)
    cyc(0, 0, 1, 1, 1, 0);          // R7
    for (int i = 0; i < 62; i++) cyc(1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);          // R4 start at zero while done
    cyc(0, 0, 1, 0, 0, 0);          // R6 done cleared by increment
    // R9 switch to stopwatch, R8 count to saturation
    cyc(1, 1, 1, 0, 0, 1);
    cyc(0, 1, 0, 0, 0, 1);
    for (int i = 0; i < 6010; i++) cyc(1, 0, 0, 0, 0, 1);
    cyc(0, 0, 1, 1, 1, 1);
    cyc(0, 1, 0, 0, 0, 1);
    // R1 reset mid-state
    do_reset(1);
    // constrained random
    for (int i = 0; i < 60000; i++) begin
      bit md;
      md = exp_mode;
      if ($urandom_range(999) < 2) md = !md;
      cyc($urandom_range(99) < 50, $urandom_range(199) == 0,
          $urandom_range(99) < 3, $urandom_range(99) < 3,
          $urandom_range(99) < 2, md);
    end
    finish_run();
  end
endmodule